// File: doc/BRIEF.md
# Dual-Enable Byte-Wide Static Memory

This block is a synthesizable behavioural model of a byte-wide static memory with two chip selects of opposite polarity, a write strobe and an output enable. Every clock edge samples the control pins and decodes them into one of four modes. In standby the device is deselected. In read it drives the addressed byte. In output-disable it stays active but does not drive. In write it stores the input byte at the addressed location.

The bidirectional data bus is split into `dq_in`, `dq_out` and a drive qualifier `dq_drive`. A pad wrapper can then build the tristate buffer, and a simulator without tristate support can still check the released state. A low-power flag reports when the last sampled cycle had the device deselected. The depth is set by `ADDR_W`. The full-size configuration uses `ADDR_W = 18`, which gives 262,144 bytes. The default is smaller so that the model stays light to elaborate.

Top module: `dual_enable_sram`

## Requirements
- R1: The array holds 2**ADDR_W bytes (262,144 when ADDR_W is 18). A byte written at any address, including address 0, the highest address and the middle of the range, reads back unchanged.
- R2: When `chip_sel_n` is sampled high, `dq_drive` is low in the next cycle and no byte is stored, whatever the other pins are.
- R3: When `chip_sel` is sampled low, `dq_drive` is low in the next cycle and no byte is stored, whatever the other pins are.
- R4: With both selects asserted, `write_n` high and `out_en_n` low (read), the cycle after sampling has `dq_drive` high and `dq_out` equal to the stored byte at the sampled address.
- R5: With both selects asserted and both `write_n` and `out_en_n` high (output disable), `dq_drive` is low in the next cycle and the array is unchanged.
- R6: With both selects asserted and `write_n` low, `dq_in` is stored at the sampled address, and `dq_drive` is low in the next cycle even when `out_en_n` is low.
- R7: `low_power` is high in the cycle after a deselected sample (R2 or R3) and low in the cycle after any sample with both selects asserted.
- R8: While and right after the synchronous reset `rst` is high, `dq_drive` is low and `low_power` is high.
- R9: `dq_out` is all zeros whenever `dq_drive` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| chip_sel_n | input | 1 | Active-low chip select |
| chip_sel | input | 1 | Active-high chip select |
| write_n | input | 1 | Active-low write strobe, overrides output enable |
| out_en_n | input | 1 | Active-low output enable |
| dq_in | input | DATA_W | Byte to store |
| dq_out | output | DATA_W | Byte read out, zero when not driven |
| dq_drive | output | 1 | High when the bus is driven |
| low_power | output | 1 | High when the last sample was deselected |

## Verification
Every result of this block appears exactly one clock after the edge that samples the pins: the drive qualifier, the read byte and the low-power flag. A byte written at one edge can be read at the next sampled cycle. The bench changes the pins at the falling edge and lets one rising edge pass. It compares at the following falling edge against a reference model that is updated only after each comparison, so a write affects only later reads.

// File: rtl/dual_enable_sram_pkg.sv
package dual_enable_sram_pkg;
  typedef enum logic [1:0] {
    MODE_STANDBY = 2'd0,
    MODE_READ    = 2'd1,
    MODE_HOLD    = 2'd2,
    MODE_WRITE   = 2'd3
  } sram_mode_e;
endpackage

// File: rtl/sram_mode_decode.sv
module sram_mode_decode
  import dual_enable_sram_pkg::*;
(
  input  logic       chip_sel_n,
  input  logic       chip_sel,
  input  logic       write_n,
  input  logic       out_en_n,
  output sram_mode_e mode
);
  logic selected;
  assign selected = !chip_sel_n && chip_sel;

  always_comb begin
    if (!selected)     mode = MODE_STANDBY;
    else if (!write_n) mode = MODE_WRITE;
    else if (!out_en_n) mode = MODE_READ;
    else               mode = MODE_HOLD;
  end
endmodule

// File: rtl/sram_cell_array.sv
module sram_cell_array #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) cells[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rd_en) rdata <= cells[addr];
  end
endmodule

// File: rtl/sram_io_stage.sv
module sram_io_stage
  import dual_enable_sram_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  sram_mode_e mode,
  output logic       drive_q,
  output logic       lowpwr_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      drive_q  <= 1'b0;
      lowpwr_q <= 1'b1;
    end else begin
      drive_q  <= (mode == MODE_READ);
      lowpwr_q <= (mode == MODE_STANDBY);
    end
  end
endmodule

// File: rtl/dual_enable_sram.sv
module dual_enable_sram
  import dual_enable_sram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chip_sel_n,
  input  logic              chip_sel,
  input  logic              write_n,
  input  logic              out_en_n,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_drive,
  output logic              low_power
);
  sram_mode_e        mode;
  logic [DATA_W-1:0] rd_byte;
  logic              drive_q;

  sram_mode_decode u_decode (
    .chip_sel_n (chip_sel_n),
    .chip_sel   (chip_sel),
    .write_n    (write_n),
    .out_en_n   (out_en_n),
    .mode       (mode)
  );

  sram_cell_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk   (clk),
    .wr_en (mode == MODE_WRITE),
    .rd_en (mode == MODE_READ),
    .addr  (addr),
    .wdata (dq_in),
    .rdata (rd_byte)
  );

  sram_io_stage u_io (
    .clk      (clk),
    .rst      (rst),
    .mode     (mode),
    .drive_q  (drive_q),
    .lowpwr_q (low_power)
  );

  assign dq_drive = drive_q;
  assign dq_out   = drive_q ? rd_byte : '0;

  p_sel_n_standby_r2: assert property (@(posedge clk) disable iff (rst)
    $past(chip_sel_n) |-> !dq_drive);
  p_sel_standby_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(chip_sel) |-> !dq_drive);
  p_read_drives_r4: assert property (@(posedge clk) disable iff (rst)
    ($past(!chip_sel_n && chip_sel && write_n && !out_en_n) && !$past(rst)) |-> dq_drive);
  p_hold_released_r5: assert property (@(posedge clk) disable iff (rst)
    $past(!chip_sel_n && chip_sel && write_n && out_en_n) |-> !dq_drive);
  p_write_released_r6: assert property (@(posedge clk) disable iff (rst)
    $past(!chip_sel_n && chip_sel && !write_n) |-> !dq_drive);
  p_deselect_lowpwr_r7: assert property (@(posedge clk) disable iff (rst)
    $past(chip_sel_n || !chip_sel) |-> low_power);
  p_active_awake_r7: assert property (@(posedge clk) disable iff (rst)
    ($past(!chip_sel_n && chip_sel) && !$past(rst)) |-> !low_power);
  p_reset_state_r8: assert property (@(posedge clk)
    $past(rst) |-> (!dq_drive && low_power));
  p_quiet_bus_r9: assert property (@(posedge clk) disable iff (rst)
    !dq_drive |-> (dq_out == '0));
endmodule

// File: tb/test_dual_enable_sram.sv
module test_dual_enable_sram;
  localparam int AW    = 10;
  localparam int DW    = 8;
  localparam int DEPTH = 1 << AW;
  localparam logic [AW-1:0] TOP_ADDR = AW'(DEPTH - 1);
  localparam logic [AW-1:0] MID_ADDR = AW'(DEPTH / 2);

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          chip_sel_n, chip_sel, write_n, out_en_n;
  logic [DW-1:0] dq_in;
  logic [DW-1:0] dq_out;
  logic          dq_drive, low_power;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] model [DEPTH];
  bit            known [DEPTH];

  always #10 clk = ~clk;

  dual_enable_sram #(.ADDR_W(AW), .DATA_W(DW)) i_dual_enable_sram (
    .clk(clk), .rst(rst), .addr(addr), .chip_sel_n(chip_sel_n),
    .chip_sel(chip_sel), .write_n(write_n), .out_en_n(out_en_n),
    .dq_in(dq_in), .dq_out(dq_out), .dq_drive(dq_drive), .low_power(low_power)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_drive(input bit sn, input bit s, input bit wn, input bit on);
    return !sn && s && wn && !on;
  endfunction

  function automatic bit exp_lowpwr(input bit sn, input bit s);
    return sn || !s;
  endfunction

  // Drive pins at the falling edge, pass one rising edge, compare at the next falling edge.
  task automatic step(input logic [AW-1:0] a, input bit sn, input bit s,
                      input bit wn, input bit on, input logic [DW-1:0] d,
                      input string req);
    bit dr;
    addr = a; chip_sel_n = sn; chip_sel = s; write_n = wn; out_en_n = on; dq_in = d;
    @(posedge clk);
    @(negedge clk);
    dr = exp_drive(sn, s, wn, on);
    check(dq_drive == dr, {req, " drive"}, int'(dq_drive), int'(dr));
    check(low_power == exp_lowpwr(sn, s), "R7 low_power", int'(low_power),
          int'(exp_lowpwr(sn, s)));
    if (dr && known[a])
      check(dq_out == model[a], {req, " data"}, int'(dq_out), int'(model[a]));
    if (!dr) check(dq_out == '0, "R9 quiet bus", int'(dq_out), 0);
    if (!sn && s && !wn) begin
      model[a] = d;
      known[a] = 1'b1;
    end
  endtask

  initial begin
    int seed_val;
    seed_val = $urandom(32'd2024);
    rst = 1'b1; addr = '0; chip_sel_n = 1'b1; chip_sel = 1'b0;
    write_n = 1'b1; out_en_n = 1'b1; dq_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!dq_drive, "R8 reset drive", int'(dq_drive), 0);
    check(low_power, "R8 reset low_power", int'(low_power), 1);
    rst = 1'b0;

    // R1: ends and middle of the range
    step('0,       0, 1, 0, 1, 8'hA5, "R6 write low");
    step(TOP_ADDR, 0, 1, 0, 0, 8'h5A, "R6 write top oe low");
    step(MID_ADDR, 0, 1, 0, 1, 8'h3C, "R6 write mid");
    step('0,       0, 1, 1, 0, 8'h00, "R1 read low");
    step(TOP_ADDR, 0, 1, 1, 0, 8'h00, "R1 read top");
    step(MID_ADDR, 0, 1, 1, 0, 8'h00, "R1 read mid");

    // R2/R3: every other-pin combination while deselected; write attempts must not store
    for (int c = 0; c < 8; c++) begin
      step(MID_ADDR, 1, c[0], c[1], c[2], 8'hFF, "R2 standby");
      step(MID_ADDR, c[0], 0, c[1], c[2], 8'hEE, "R3 standby");
    end
    step(MID_ADDR, 0, 1, 1, 0, 8'h00, "R2 R3 no store");
    check(dq_out == 8'h3C, "R2 R3 mid unchanged", int'(dq_out), 32'h3C);

    // R5: output disable leaves bus released and array intact
    step(TOP_ADDR, 0, 1, 1, 1, 8'h11, "R5 output disable");
    step(TOP_ADDR, 0, 1, 1, 0, 8'h00, "R5 read after disable");
    check(dq_out == 8'h5A, "R5 top unchanged", int'(dq_out), 32'h5A);

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      logic [AW-1:0] ra;
      int pick;
      pick = int'($urandom_range(0, 9));
      if (pick == 0)      ra = '0;
      else if (pick == 1) ra = TOP_ADDR;
      else                ra = AW'($urandom_range(0, 31));
      step(ra, ($urandom_range(0, 5) == 0), ($urandom_range(0, 5) != 0),
           ($urandom_range(0, 2) != 0), $urandom_range(0, 1) == 1,
           DW'($urandom), "R4 random");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    n_tests++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule